// File: doc/BRIEF.md
# Segmented Bus Interface Unit

This block is the bus side of a 16-bit processor core. It holds the segment registers and the instruction pointer. It turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address, and it runs every cycle on a simple synchronous memory bus. The execution side never drives the bus. It asks this block for data reads and writes, and it takes instruction bytes one at a time from a six-byte prefetch queue.

Whenever the bus is free and the queue has room for a whole word, the block reads the next word of code. The code address is formed from the code segment and the instruction pointer. A data request takes priority over a prefetch at the next cycle boundary. A flush, used on a change of flow, empties the queue, drops any code word still in flight and restarts fetching from a new offset.

Top module: `segBiu`

## Requirements
- R1: Every physical address is (segment × 16 + offset) modulo 2^20, so a carry out of bit 19 is lost. Segment 0x1234 with offset 0x0022 gives 0x12362. Segment 0xFFFF with offset 0xFFFF gives 0x0FFEF. Segment 0xFFFF with offset 0x0010 gives 0x00000.
- R2: There are four segment registers, selected by codes 0 to 3, and code 1 is the code segment. A register is loaded through `segWe`/`segSel`/`segWdata`, and the new value takes effect from the next cycle. After reset the code segment holds `RESET_CS` and the others hold 0.
- R3: Each data request runs exactly one bus cycle. That cycle has `memWe` = `dWe` and `memWdata` = `dWdata`, and its address is formed from segment `dSeg` and `dOffset`. `dAck` is high for exactly the one cycle in which `memAck` ends that bus cycle, and in that cycle `dRdata` equals `memRdata`.
- R4: Bytes leave the fetch port in instruction-pointer order, with the offset wrapping at 16 bits. The byte at an even physical address is bits 7:0 of the word read there. The byte at an odd physical address is bits 15:8 of the word at the address below it.
- R5: `fetchValid` is high exactly when the queue holds a byte. A byte is removed only on a cycle with `fetchValid` and `fetchReady` both high. While no byte is removed, `fetchByte` holds its value.
- R6: A prefetch starts only when at least 2 of the 6 queue entries are free. It is a read (`memWe` = 0) at the even address of the word that holds the byte at code segment : instruction pointer.
- R7: When the instruction pointer is odd, a prefetch pushes only the upper byte of the word and advances the pointer by 1. Otherwise it pushes the lower byte and then the upper byte, and advances the pointer by 2.
- R8: A data request that is pending when the bus is idle starts ahead of any prefetch. Once a bus cycle has started, `memReq`, `memAddr` and `memWe` hold steady until `memAck`.
- R9: A flush leaves the queue empty on the next cycle. The word of any prefetch still in flight is thrown away. Fetching restarts at `flushIp`.
- R10: While reset is held, `memReq`, `fetchValid` and `dAck` are low. The first bus cycle after reset is a prefetch at `RESET_CS`:`RESET_IP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memReq | output | 1 | A bus cycle is in progress |
| memWe | output | 1 | The bus cycle is a write |
| memAddr | output | ADDR_W | Physical byte address of the bus cycle |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid together with memAck |
| memAck | input | 1 | Completes the current bus cycle |
| fetchValid | output | 1 | The queue holds an instruction byte |
| fetchByte | output | 8 | Oldest byte in the queue |
| fetchReady | input | 1 | The execution side takes the byte |
| dReq | input | 1 | Data request, held until dAck |
| dWe | input | 1 | The data request is a write |
| dSeg | input | 2 | Segment register code for the request |
| dOffset | input | OFF_W | Offset for the request (pointer or immediate) |
| dWdata | input | 16 | Data to write |
| dAck | output | 1 | Data request done |
| dRdata | output | 16 | Data read |
| segWe | input | 1 | Load a segment register |
| segSel | input | 2 | Segment register to load |
| segWdata | input | OFF_W | New segment value |
| flush | input | 1 | Empty the queue and reload the pointer |
| flushIp | input | OFF_W | New instruction pointer |

## Verification
The hardest state to reach from the ports is a flush that lands while a prefetch is in flight, and most of all on the very cycle its `memAck` arrives. In that case the returned word must vanish rather than reach the queue. The bench model of the memory adds random wait states and issues flushes at random while the prefetch engine is nearly always busy, so flushes fall at every point of a prefetch cycle. A queue-occupancy model then checks `fetchValid` on every cycle, which catches a discarded word that slips through. Directed flushes to offsets 0x0101 and 0xFFFF also reach an odd restart, a single-byte push and the wrap of the pointer at 16 bits.

// File: rtl/segBiuPkg.sv
`timescale 1ns/1ps
package segBiuPkg;
  localparam int WORD_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int CODE_SEG = 1;

  typedef enum logic [1:0] {BUS_IDLE, BUS_PREF, BUS_DATA} busState_t;

  typedef struct packed {
    logic startPref;
    logic startData;
    logic pushPref;
    logic loadIp;
  } biuStrobes_t;
endpackage

// File: rtl/segBiuDatapath.sv
`timescale 1ns/1ps
module segBiuDatapath
  import segBiuPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFF_W = 16,
  parameter int QUEUE_DEPTH = 6,
  parameter int SEG_COUNT = 4,
  parameter logic [OFF_W-1:0] RESET_CS = '1,
  parameter logic [OFF_W-1:0] RESET_IP = '0
) (
  input  logic clk,
  input  logic rstN,
  input  biuStrobes_t st,
  input  logic [$clog2(SEG_COUNT)-1:0] dSeg,
  input  logic [OFF_W-1:0] dOffset,
  input  logic dWe,
  input  logic [WORD_W-1:0] dWdata,
  input  logic segWe,
  input  logic [$clog2(SEG_COUNT)-1:0] segSel,
  input  logic [OFF_W-1:0] segWdata,
  input  logic [OFF_W-1:0] flushIp,
  input  logic [WORD_W-1:0] memRdata,
  input  logic fetchReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic memWe,
  output logic [WORD_W-1:0] memWdata,
  output logic fetchValid,
  output logic [BYTE_W-1:0] fetchByte,
  output logic roomOk
);
  localparam int SHIFT = ADDR_W - OFF_W;
  localparam int PW = $clog2(QUEUE_DEPTH);
  localparam int CW = $clog2(QUEUE_DEPTH + 1);

  logic [OFF_W-1:0] segRegs [SEG_COUNT];
  logic [OFF_W-1:0] ip;
  logic curOdd;
  logic [BYTE_W-1:0] qMem [QUEUE_DEPTH];
  logic [PW-1:0] headPtr, tailPtr;
  logic [CW-1:0] count, countNext;
  logic [ADDR_W-1:0] prefAddr, dataAddr;
  logic pop;
  logic [CW-1:0] pushN;

  // Dedicated adder: shifted segment plus offset, carry out of the top bit dropped
  function automatic logic [ADDR_W-1:0] formAddr(input logic [OFF_W-1:0] seg,
                                                 input logic [OFF_W-1:0] off);
    return {seg, {SHIFT{1'b0}}} + ADDR_W'(off);
  endfunction

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= QUEUE_DEPTH) s = s - QUEUE_DEPTH;
    return PW'(s);
  endfunction

  assign prefAddr = formAddr(segRegs[CODE_SEG], ip);
  assign dataAddr = formAddr(segRegs[dSeg], dOffset);
  assign fetchValid = (count != '0);
  assign fetchByte = qMem[headPtr];
  assign roomOk = (count <= CW'(QUEUE_DEPTH - 2));
  assign pop = fetchValid && fetchReady && !st.loadIp;

  always_comb begin
    pushN = '0;
    if (st.pushPref) pushN = curOdd ? CW'(1) : CW'(2);
    countNext = count + pushN - CW'(pop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SEG_COUNT; i++)
        segRegs[i] <= (i == CODE_SEG) ? RESET_CS : '0;
    end else if (segWe) begin
      segRegs[segSel] <= segWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ip <= RESET_IP;
      curOdd <= 1'b0;
      memAddr <= '0;
      memWe <= 1'b0;
      memWdata <= '0;
    end else begin
      if (st.loadIp) begin
        ip <= flushIp;
      end else if (st.startPref) begin
        ip <= ip + (ip[0] ? OFF_W'(1) : OFF_W'(2));
        curOdd <= ip[0];
        memAddr <= {prefAddr[ADDR_W-1:1], 1'b0};
        memWe <= 1'b0;
      end
      if (st.startData) begin
        memAddr <= dataAddr;
        memWe <= dWe;
        memWdata <= dWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count <= '0;
    end else if (st.loadIp) begin
      headPtr <= '0;
      tailPtr <= '0;
      count <= '0;
    end else begin
      if (pop) headPtr <= bump(headPtr, 1);
      if (st.pushPref) tailPtr <= bump(tailPtr, curOdd ? 1 : 2);
      count <= countNext;
    end
  end

  always_ff @(posedge clk) begin
    if (st.pushPref) begin
      if (curOdd) begin
        qMem[tailPtr] <= memRdata[WORD_W-1:BYTE_W];
      end else begin
        qMem[tailPtr] <= memRdata[BYTE_W-1:0];
        qMem[bump(tailPtr, 1)] <= memRdata[WORD_W-1:BYTE_W];
      end
    end
  end
endmodule

// File: rtl/segBiuControl.sv
`timescale 1ns/1ps
module segBiuControl
  import segBiuPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic dReq,
  input  logic flush,
  input  logic memAck,
  input  logic roomOk,
  output biuStrobes_t st,
  output logic memReq,
  output logic dAck
);
  busState_t state, stateNext;
  logic discard;

  always_comb begin
    stateNext = state;
    st = '0;
    st.loadIp = flush;
    unique case (state)
      BUS_IDLE: begin
        if (dReq) begin
          st.startData = 1'b1;
          stateNext = BUS_DATA;
        end else if (!flush && roomOk) begin
          st.startPref = 1'b1;
          stateNext = BUS_PREF;
        end
      end
      BUS_PREF: begin
        if (memAck) begin
          st.pushPref = !discard && !flush;
          stateNext = BUS_IDLE;
        end
      end
      BUS_DATA: begin
        if (memAck) stateNext = BUS_IDLE;
      end
      default: stateNext = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= BUS_IDLE;
      discard <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == BUS_PREF && memAck) discard <= 1'b0;
      else if (state == BUS_PREF && flush) discard <= 1'b1;
    end
  end

  assign memReq = (state != BUS_IDLE);
  assign dAck = (state == BUS_DATA) && memAck;
endmodule

// File: rtl/segBiu.sv
`timescale 1ns/1ps
module segBiu
  import segBiuPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFF_W = 16,
  parameter int QUEUE_DEPTH = 6,
  parameter int SEG_COUNT = 4,
  parameter logic [OFF_W-1:0] RESET_CS = '1,
  parameter logic [OFF_W-1:0] RESET_IP = '0
) (
  input  logic clk,
  input  logic rstN,
  output logic memReq,
  output logic memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic memAck,
  output logic fetchValid,
  output logic [BYTE_W-1:0] fetchByte,
  input  logic fetchReady,
  input  logic dReq,
  input  logic dWe,
  input  logic [$clog2(SEG_COUNT)-1:0] dSeg,
  input  logic [OFF_W-1:0] dOffset,
  input  logic [WORD_W-1:0] dWdata,
  output logic dAck,
  output logic [WORD_W-1:0] dRdata,
  input  logic segWe,
  input  logic [$clog2(SEG_COUNT)-1:0] segSel,
  input  logic [OFF_W-1:0] segWdata,
  input  logic flush,
  input  logic [OFF_W-1:0] flushIp
);
  biuStrobes_t st;
  logic roomOk;

  segBiuControl ctrl (
    .clk(clk), .rstN(rstN), .dReq(dReq), .flush(flush), .memAck(memAck),
    .roomOk(roomOk), .st(st), .memReq(memReq), .dAck(dAck)
  );

  segBiuDatapath #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .QUEUE_DEPTH(QUEUE_DEPTH),
    .SEG_COUNT(SEG_COUNT), .RESET_CS(RESET_CS), .RESET_IP(RESET_IP)
  ) dp (
    .clk(clk), .rstN(rstN), .st(st), .dSeg(dSeg), .dOffset(dOffset),
    .dWe(dWe), .dWdata(dWdata), .segWe(segWe), .segSel(segSel),
    .segWdata(segWdata), .flushIp(flushIp), .memRdata(memRdata),
    .fetchReady(fetchReady), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .fetchValid(fetchValid), .fetchByte(fetchByte),
    .roomOk(roomOk)
  );

  assign dRdata = memRdata;
endmodule

// File: rtl/segBiuChecker.sv
`timescale 1ns/1ps
module segBiuChecker #(
  parameter int ADDR_W = 20
) (
  input logic clk,
  input logic rstN,
  input logic memReq,
  input logic memAck,
  input logic memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic fetchValid,
  input logic fetchReady,
  input logic [7:0] fetchByte,
  input logic flush,
  input logic dAck
);
  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));
  // R3
  dack_with_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    dAck |-> memReq && memAck);
  // R3
  dack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    dAck |=> !dAck);
  // R3
  cycle_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> !memReq);
  // R5
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !fetchReady && !flush |=> fetchValid && $stable(fetchByte));
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !fetchValid);
endmodule

bind segBiu segBiuChecker #(.ADDR_W(ADDR_W)) segBiuChk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memWe(memWe),
  .memAddr(memAddr), .fetchValid(fetchValid), .fetchReady(fetchReady),
  .fetchByte(fetchByte), .flush(flush), .dAck(dAck)
);

// File: tb/segBiu_test.sv
`timescale 1ns/1ps
module segBiu_test;
  localparam int QD = 6;
  localparam logic [15:0] CS0 = 16'hFFFF;
  localparam logic [15:0] IP0 = 16'h0000;

  logic clk = 1'b0;
  logic rstN;
  logic memReq, memWe, memAck, fetchValid, fetchReady, dReq, dWe, dAck;
  logic segWe, flush;
  logic [19:0] memAddr;
  logic [15:0] memWdata, memRdata, dOffset, dWdata, dRdata, segWdata, flushIp;
  logic [7:0] fetchByte;
  logic [1:0] dSeg, segSel;

  always #5 clk = ~clk;

  segBiu uut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .fetchValid(fetchValid), .fetchByte(fetchByte), .fetchReady(fetchReady),
    .dReq(dReq), .dWe(dWe), .dSeg(dSeg), .dOffset(dOffset), .dWdata(dWdata),
    .dAck(dAck), .dRdata(dRdata), .segWe(segWe), .segSel(segSel),
    .segWdata(segWdata), .flush(flush), .flushIp(flushIp)
  );

  int checks = 0, errors = 0;
  bit running = 0, done = 0, timedOut = 0;
  logic [15:0] segM [4];
  logic [15:0] benchIp, benchPrefIp;
  int qModel, waitLeft, dWait, dirIdx;
  bit lastPop, lastPopPrev, memReqPrev, dReqPrev, inFlight, curIsData;
  bit curDiscard, curOdd, firstPref, flushPrev;
  logic [19:0] expAddr;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    logic [31:0] s;
    s = 32'(seg) * 16 + 32'(off);
    return s[19:0];
  endfunction

  function automatic logic [15:0] memWord(input logic [19:0] a);
    logic [19:0] e;
    e = {a[19:1], 1'b0};
    return e[15:0] ^ {e[19:16], e[15:4]} ^ 16'h5A3C;
  endfunction

  function automatic logic [7:0] memByte(input logic [19:0] a);
    logic [15:0] w;
    w = memWord(a);
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  task automatic issueReq(input logic [1:0] s, input logic [15:0] off, input bit we,
                          input logic [15:0] wd, input logic [19:0] exp);
    dReq = 1; dSeg = s; dOffset = off; dWe = we; dWdata = wd; expAddr = exp;
  endtask

  task automatic writeSeg(input logic [1:0] s, input logic [15:0] v);
    segWe = 1; segSel = s; segWdata = v; segM[s] = v;
  endtask

  task automatic doFlush(input logic [15:0] ip, input bit newCs, input logic [15:0] cs);
    flush = 1; flushIp = ip; benchIp = ip; benchPrefIp = ip; qModel = 0;
    if (inFlight && !curIsData) curDiscard = 1;
    if (newCs) writeSeg(2'd1, cs);
  endtask

  always @(negedge clk) begin
    if (running && !done) begin
      dReqPrev = dReq;
      lastPopPrev = lastPop;
      lastPop = 0;
      // memory model
      if (memAck) begin
        memAck = 0;
        if (!curIsData && !curDiscard) qModel += curOdd ? 1 : 2;  // R7 push size
        if (curIsData) dReq = 0;
        inFlight = 0;
      end else if (memReq) begin
        if (!memReqPrev) begin
          inFlight = 1; curDiscard = 0;
          curIsData = dReqPrev;
          if (curIsData) begin
            // R8 data request pending at the boundary must win
            check(memAddr == expAddr && memWe == dWe, "R8 data first / R1 address",
                  {12'h0, memAddr}, {12'h0, expAddr});
            if (dWe) check(memWdata == dWdata, "R3 write data", memWdata, dWdata);
          end else begin
            logic [19:0] pa;
            pa = phys(segM[1], benchPrefIp);
            pa[0] = 1'b0;
            check(memWe == 0 && memAddr == pa,
                  firstPref ? "R10 first prefetch" : (benchPrefIp[0] ? "R7 odd prefetch" : "R6 prefetch address"),
                  {12'h0, memAddr}, {12'h0, pa});
            check(qModel + int'(lastPopPrev) <= QD - 2, "R6 room", qModel + int'(lastPopPrev), QD - 2);
            firstPref = 0;
            curOdd = benchPrefIp[0];
            benchPrefIp = benchPrefIp + (curOdd ? 16'd1 : 16'd2);
          end
        end
        if (waitLeft == 0) begin
          memAck = 1;
          memRdata = memWord(memAddr);
          waitLeft = $urandom % 3;
          #1;
          if (curIsData) begin
            check(dAck == 1, "R3 dAck", dAck, 1);
            check(dRdata == memWord(expAddr), "R3 read data", dRdata, memWord(expAddr));
          end else begin
            check(dAck == 0, "R3 no dAck on prefetch", dAck, 0);
          end
        end else begin
          waitLeft--;
        end
      end
      memReqPrev = memReq;
      check(fetchValid == (qModel != 0), "R5 valid vs occupancy", fetchValid, qModel);
      if (flushPrev) check(fetchValid == 0, "R9 flush empties", fetchValid, 0);
      // stimulus
      flushPrev = 0; flush = 0; segWe = 0;
      if (!dReq) begin
        if (dirIdx < 8) begin
          case (dirIdx)
            0: issueReq(2'd2, 16'hABCD, 0, 16'h0, 20'h0ABCD);   // R2 reset value 0
            1: writeSeg(2'd3, 16'h1234);                        // R2
            2: writeSeg(2'd0, 16'hFFFF);
            3: issueReq(2'd3, 16'h0022, 1, 16'hBEEF, 20'h12362); // R1 example
            4: issueReq(2'd0, 16'hFFFF, 0, 16'h0, 20'h0FFEF);   // R1 carry lost
            5: issueReq(2'd0, 16'h0010, 0, 16'h0, 20'h00000);   // R1 wrap to zero
            6: doFlush(16'h0101, 1, 16'h2000);                  // R7 odd restart
            default: doFlush(16'hFFFF, 0, 16'h0);               // R4 offset wrap
          endcase
          dirIdx++;
        end else begin
          int r;
          r = $urandom % 100;
          if (r < 2) begin
            logic [15:0] nip;
            nip = ($urandom % 4 == 0) ? (16'hFFFE | 16'($urandom % 2)) : 16'($urandom);
            doFlush(nip, ($urandom % 3) == 0, 16'($urandom));
          end else if (r < 5) begin
            logic [1:0] s;
            s = 2'($urandom % 3);
            if (s == 2'd1) s = 2'd3;
            writeSeg(s, 16'($urandom));
          end else if (r < 18) begin
            logic [1:0] s;
            logic [15:0] off;
            s = 2'($urandom % 4);
            off = 16'($urandom);
            issueReq(s, off, $urandom % 2, 16'($urandom), phys(segM[s], off));
          end
        end
      end
      flushPrev = flush;
      // consumer
      if (flush) fetchReady = 0;
      else fetchReady = ($urandom % 10) < 6;
      if (fetchReady && fetchValid) begin
        logic [7:0] eb;
        eb = memByte(phys(segM[1], benchIp));
        check(fetchByte == eb, "R4 fetch byte", fetchByte, eb);
        benchIp = benchIp + 16'd1;
        qModel--;
        lastPop = 1;
      end
      if (dReq) dWait++; else dWait = 0;
      if (dWait > 100) begin
        timedOut = 1;
        done = 1;
      end
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rstN = 0; memAck = 0; memRdata = 0; fetchReady = 0; dReq = 0; dWe = 0;
    dSeg = 0; dOffset = 0; dWdata = 0; segWe = 0; segSel = 0; segWdata = 0;
    flush = 0; flushIp = 0;
    segM[0] = 0; segM[1] = CS0; segM[2] = 0; segM[3] = 0;
    benchIp = IP0; benchPrefIp = IP0; qModel = 0; waitLeft = 1; dWait = 0; dirIdx = 0;
    lastPop = 0; memReqPrev = 0; inFlight = 0; curIsData = 0; curDiscard = 0;
    curOdd = 0; firstPref = 1; flushPrev = 0;
    repeat (3) begin
      @(negedge clk);
      // R10 reset state
      check(memReq == 0 && fetchValid == 0 && dAck == 0, "R10 reset outputs",
            {memReq, fetchValid, dAck}, 0);
    end
    rstN = 1;
    running = 1;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    running = 0;
    if (timedOut) begin
      errors++;
      checks++;
      $display("FAIL watchdog: data request not acknowledged actual %0d expected %0d", dWait, 100);
    end
    check(dirIdx >= 8, "R1 directed cases reached", dirIdx, 8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule